// File: doc/BRIEF.md
# Two-Bank Interleaved Data Memory Interface

This block sits between a 32-bit processor datapath and a data memory built from two 16-bit banks, one even and one odd. Every access is steered by four explicit control bits rather than by decoding the address: one bit enables the access, one chooses write or read, one chooses the odd bank over the even bank for a single 16-bit word, and one requests a 32-bit double word that spans both banks at the same address.

A store can therefore place one 16-bit word in either bank, or a full 32-bit word split across the pair. A load returns the chosen word zero-extended, or the joined double word, on a registered output that feeds the write-back multiplexer of the register file. The banks are held inside the block as plain register arrays written so that block RAM can be inferred. When the access enable is low, nothing is written and the read output keeps its last value.

Top module: `dmem_two_bank`

## Requirements
- R1: After synchronous reset, `rdata` is zero.
- R2: The control field is `mem_ctl[3]` double, `mem_ctl[2]` access enable, `mem_ctl[1]` write (1 = write, 0 = read), `mem_ctl[0]` odd select (1 = odd bank). An even word store (code 4'b0110) writes `wdata[15:0]` into the even bank at `addr` on the rising edge and leaves the odd bank at that address unchanged.
- R3: An odd word store (code 4'b0111) writes `wdata[15:0]` into the odd bank at `addr` and leaves the even bank at that address unchanged.
- R4: A double store (`mem_ctl[3]`, `[2]` and `[1]` set, `mem_ctl[0]` ignored) writes `wdata[15:0]` into the even bank and `wdata[31:16]` into the odd bank, both at `addr`.
- R5: An even word load (code 4'b0100) sets `rdata` to `{16'h0, even[addr]}` one clock after the request.
- R6: An odd word load (code 4'b0101) sets `rdata` to `{16'h0, odd[addr]}` one clock after the request; the upper half is always zero for a single-word load.
- R7: A double load (`mem_ctl[3]` and `[2]` set, `[1]` clear, `[0]` ignored) sets `rdata` to `{odd[addr], even[addr]}` one clock after the request.
- R8: With `mem_ctl[2]` low, no bank is written whatever the other bits are, and `rdata` holds its value.
- R9: A store of any kind leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_ctl | input | 4 | Access control: double, enable, write, odd select |
| addr | input | 8 | Word address applied to both banks |
| wdata | input | 32 | Store data |
| rdata | output | 32 | Registered load data for the write-back multiplexer |

## Verification
The whole memory is first filled with double stores, so every later load has a known value in both banks and a single-word store that disturbs the wrong bank shows up when the other half is read back. Directed sequences then store to the even bank, the odd bank and both banks at distinct addresses and read each back as even, odd and double, which separates lane mix-ups, missing zero-extension and halves swapped in a double word. Random control codes over a small address window mix idle cycles, stores and loads back to back, telling apart a read output that holds correctly from one that follows writes or idle cycles, and exercising the ignored odd bit on double accesses.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  // Control field, bit 3 down to bit 0.
  typedef struct packed {
    logic dbl;   // double word across both banks
    logic sel;   // access enable
    logic wr;    // 1 = store, 0 = load
    logic odd;   // single word goes to the odd bank
  } mem_ctl_t;

  typedef enum logic [1:0] {
    LANE_EVEN = 2'd0,
    LANE_ODD  = 2'd1,
    LANE_DBL  = 2'd2
  } lane_t;

  localparam int NUM_BANKS = 2;

endpackage

// File: rtl/dmem_bank.sv
module dmem_bank #(
  parameter int AW = 8,
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [HW-1:0] wd,
  output logic [HW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [HW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
  end

  // Registered read port, output register with synchronous reset.
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= mem[addr];
  end
endmodule

// File: rtl/dmem_ctl_decode.sv
module dmem_ctl_decode
  import dmem_pkg::*;
(
  input  mem_ctl_t ctl,
  output logic     we_even,
  output logic     we_odd,
  output logic     rd_en,
  output lane_t    lane
);
  logic store;

  always_comb begin
    store   = ctl.sel & ctl.wr;
    we_even = store & (ctl.dbl | ~ctl.odd);
    we_odd  = store & (ctl.dbl |  ctl.odd);
    rd_en   = ctl.sel & ~ctl.wr;
    if (ctl.dbl)      lane = LANE_DBL;
    else if (ctl.odd) lane = LANE_ODD;
    else              lane = LANE_EVEN;
  end
endmodule

// File: rtl/dmem_rd_steer.sv
module dmem_rd_steer
  import dmem_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  lane_t         lane,
  input  logic [HW-1:0] q_even,
  input  logic [HW-1:0] q_odd,
  output logic [2*HW-1:0] rdata
);
  lane_t lane_q;

  // Lane of the last load; only moves together with the bank output registers.
  always_ff @(posedge clk) begin
    if (rst)        lane_q <= LANE_EVEN;
    else if (rd_en) lane_q <= lane;
  end

  always_comb begin
    unique case (lane_q)
      LANE_DBL: rdata = {q_odd, q_even};
      LANE_ODD: rdata = {{HW{1'b0}}, q_odd};
      default:  rdata = {{HW{1'b0}}, q_even};
    endcase
  end
endmodule

// File: rtl/dmem_two_bank.sv
module dmem_two_bank
  import dmem_pkg::*;
#(
  parameter int AW = 8,
  parameter int HW = 16,
  localparam int DW = 2 * HW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    mem_ctl,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  mem_ctl_t ctl;
  lane_t    lane;
  logic     we_even, we_odd, rd_en;

  logic [NUM_BANKS-1:0] bank_we;
  logic [HW-1:0]        bank_wd [NUM_BANKS];
  logic [HW-1:0]        bank_q  [NUM_BANKS];

  assign ctl = mem_ctl_t'(mem_ctl);

  dmem_ctl_decode u_dec (
    .ctl     (ctl),
    .we_even (we_even),
    .we_odd  (we_odd),
    .rd_en   (rd_en),
    .lane    (lane)
  );

  assign bank_we    = {we_odd, we_even};
  assign bank_wd[0] = wdata[HW-1:0];
  // Odd bank takes the upper half for a double word, the lower half otherwise.
  assign bank_wd[1] = ctl.dbl ? wdata[DW-1:HW] : wdata[HW-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dmem_bank #(.AW(AW), .HW(HW)) u_bank (
      .clk  (clk),
      .rst  (rst),
      .we   (bank_we[b]),
      .re   (rd_en),
      .addr (addr),
      .wd   (bank_wd[b]),
      .q    (bank_q[b])
    );
  end

  dmem_rd_steer #(.HW(HW)) u_steer (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .lane   (lane),
    .q_even (bank_q[0]),
    .q_odd  (bank_q[1]),
    .rdata  (rdata)
  );
endmodule

// File: rtl/dmem_two_bank_chk.sv
module dmem_two_bank_chk #(
  parameter int AW = 8,
  parameter int HW = 16,
  localparam int DW = 2 * HW
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    mem_ctl,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata
);
  // R8: idle cycle keeps the load output
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !mem_ctl[2] |=> $stable(rdata));

  // R9: stores keep the load output
  p_hold_store_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_ctl[2] && mem_ctl[1]) |=> $stable(rdata));

  // R6: single-word loads are zero-extended
  p_zero_ext_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_ctl[2] && !mem_ctl[1] && !mem_ctl[3]) |=> (rdata[DW-1:HW] == '0));

  // R5: even store then even load of the same address returns the stored word
  p_even_rdback_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_ctl == 4'b0110) ##1 (mem_ctl == 4'b0100 && addr == $past(addr))
    |=> (rdata == {{HW{1'b0}}, $past(wdata[HW-1:0], 2)}));

  // R7: double store then double load of the same address returns the full word
  p_dbl_rdback_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_ctl == 4'b1110) ##1 (mem_ctl == 4'b1100 && addr == $past(addr))
    |=> (rdata == $past(wdata, 2)));
endmodule

bind dmem_two_bank dmem_two_bank_chk #(.AW(AW), .HW(HW)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .mem_ctl (mem_ctl),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata)
);

// File: tb/dmem_two_bank_tb_top.sv
`timescale 1ns/1ps
module dmem_two_bank_tb_top;
  localparam int AW    = 8;
  localparam int HW    = 16;
  localparam int DW    = 2 * HW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [3:0]    mem_ctl;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [HW-1:0] em [DEPTH];
  logic [HW-1:0] om [DEPTH];
  logic [DW-1:0] exp_rd;

  always #2 clk = ~clk;

  dmem_two_bank #(.AW(AW), .HW(HW)) dut_i (
    .clk (clk), .rst (rst), .mem_ctl (mem_ctl),
    .addr (addr), .wdata (wdata), .rdata (rdata)
  );

  function automatic string auto_tag(input logic [3:0] c);
    if (!c[2])      return "R8";
    else if (c[1])  return "R9";
    else if (c[3])  return "R7";
    else if (c[0])  return "R6";
    else            return "R5";
  endfunction

  function automatic logic [DW-1:0] load_value(input logic [3:0] c, input logic [AW-1:0] a);
    if (c[3])      return {om[a], em[a]};
    else if (c[0]) return {{HW{1'b0}}, om[a]};
    else           return {{HW{1'b0}}, em[a]};
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rdata=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after sampling.
  task automatic op(input logic [3:0] c, input logic [AW-1:0] a,
                    input logic [DW-1:0] d, input string tag);
    mem_ctl = c; addr = a; wdata = d;
    if (c[2] && !c[1]) exp_rd = load_value(c, a);
    if (c[2] && c[1]) begin
      if (c[3]) begin em[a] = d[HW-1:0]; om[a] = d[DW-1:HW]; end
      else if (c[0]) om[a] = d[HW-1:0];
      else           em[a] = d[HW-1:0];
    end
    @(negedge clk);
    check((tag == "") ? auto_tag(c) : tag, rdata, exp_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; mem_ctl = '0; addr = '0; wdata = '0;
    exp_rd = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", rdata, '0);

    // R4: fill both banks with double stores (odd bit set on some, ignored)
    for (int i = 0; i < DEPTH; i++)
      op({3'b111, i[0]}, AW'(i), {16'hA000 | 16'(i), 16'h5000 | 16'(i)}, "R4");

    // R2: even store leaves odd half intact
    op(4'b0110, 8'h10, 32'hFFFF_1234, "R2");
    op(4'b0100, 8'h10, '0, "R2");
    check("R2", rdata, 32'h0000_1234);
    op(4'b0101, 8'h10, '0, "R2");
    check("R2", rdata, 32'h0000_A010);

    // R3: odd store leaves even half intact
    op(4'b0111, 8'h20, 32'hEEEE_BEEF, "R3");
    op(4'b1100, 8'h20, '0, "R3");
    check("R3", rdata, 32'hBEEF_5020);

    // R4/R7: double store then double and split loads
    op(4'b1111, 8'h30, 32'hCAFE_F00D, "R4");
    op(4'b1101, 8'h30, '0, "R7");
    check("R7", rdata, 32'hCAFE_F00D);
    op(4'b0100, 8'h30, '0, "R5");
    check("R5", rdata, 32'h0000_F00D);
    op(4'b0101, 8'h30, '0, "R6");
    check("R6", rdata, 32'h0000_CAFE);

    // R8: disabled store pattern writes nothing and holds rdata
    op(4'b1010, 8'h30, 32'h1111_2222, "R8");
    check("R8", rdata, 32'h0000_CAFE);
    op(4'b1100, 8'h30, '0, "R8");
    check("R8", rdata, 32'hCAFE_F00D);

    // R9: store right after a load keeps rdata
    op(4'b0110, 8'h40, 32'h0000_7777, "R9");
    check("R9", rdata, 32'hCAFE_F00D);

    // Random mix over a small window plus occasional wide addresses
    for (int n = 0; n < 600; n++) begin
      logic [3:0]    c;
      logic [AW-1:0] a;
      c = 4'($urandom);
      a = ($urandom % 4 == 0) ? AW'($urandom) : AW'($urandom % 8);
      op(c, a, $urandom, "");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule